// File: doc/BRIEF.md
# Ethernet Port Duplex Filter

This block sits between the per-port PHY receive signals and the MAC of a four-port Ethernet controller and decides, port by port, whether the port runs half or full duplex. Each port's mode comes from two sources: a board-level select pin, where a high level asks for half duplex, and a software configuration bit, where a high level asks for full duplex. Half duplex is chosen only when both sources ask for it. The resolved mode is reported on a status output.

The mode then shapes what the MAC sees. In full duplex the collision input is suppressed, and carrier that only echoes the port's own transmit enable is masked. In half duplex, with a per-port drop-enable bit set, a receive frame whose carrier began while the port was transmitting is treated as the PHY's loopback of that transmission. The block flags it for discard from frame start until frame end.

The select pins are asynchronous and pass through a two-stage synchroniser. A new mode is only applied while the port is idle, so the mode never changes in the middle of a frame. The reset input is asserted asynchronously and released through a two-flop synchroniser.

Top module: `eth_duplex_filter`

## Requirements
- R1: While reset is held, every port reports half duplex (`full_o` bit = 0), `rx_drop_o` is all zero, and `col_o`/`crs_o` are zero while their inputs are zero.
- R2: A port resolves to half duplex only when its `cfg_full_i` bit is 0 and its synchronised `pin_half_i` bit is 1. The other three combinations resolve to full duplex (`full_o` bit = 1).
- R3: When the port is idle, a change of `cfg_full_i` shows on `full_o` after the first rising clock edge. A change of `pin_half_i` shows after the third rising edge, because it passes two synchroniser flops and then the mode register.
- R4: The mode register of a port is loaded only at an edge where that port's `tx_en_i` and `crs_i` are both low. Otherwise it holds, and a pending change takes effect at the first idle edge.
- R5: In full duplex, `col_o` of the port is 0 whatever `col_i` does. In half duplex, `col_o` follows `col_i` in the same cycle.
- R6: In full duplex, `crs_o` = `crs_i` AND NOT `tx_en_i`. In half duplex, `crs_o` follows `crs_i` in the same cycle.
- R7: A receive frame counts as self-looped when the most recent rising edge of `crs_i`, sampled at a clock edge at or before the `rx_sof_i` edge, was seen while `tx_en_i` was high.
- R8: In half duplex with `own_drop_i` set, a self-looped frame raises `rx_drop_o` at the edge that samples `rx_sof_i`. The flag stays high until the edge that samples `rx_eof_i`, after which it is low.
- R9: `rx_drop_o` stays low for a frame that is not self-looped, for a frame received with `own_drop_i` clear, and for any frame received in full duplex.
- R10: Ports are independent. Stimulus on one port changes none of another port's outputs.
- R11: When `rx_sof_i` and `rx_eof_i` are sampled at the same edge, the frame start wins and the discard flag is loaded for the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_half_i | input | NPORT | Per-port duplex select pin, 1 = half duplex request (asynchronous) |
| cfg_full_i | input | NPORT | Per-port configuration bit, 1 = full duplex |
| own_drop_i | input | NPORT | Per-port enable for discarding self-looped receive frames |
| tx_en_i | input | NPORT | Per-port transmit enable from the MAC |
| crs_i | input | NPORT | Per-port carrier sense from the PHY |
| col_i | input | NPORT | Per-port collision from the PHY |
| rx_sof_i | input | NPORT | Per-port receive frame start strobe |
| rx_eof_i | input | NPORT | Per-port receive frame end strobe |
| crs_o | output | NPORT | Gated carrier sense to the MAC |
| col_o | output | NPORT | Gated collision to the MAC |
| rx_drop_o | output | NPORT | Discard flag for the current receive frame |
| full_o | output | NPORT | Resolved duplex status, 1 = full duplex |

## Verification
The gated carrier and collision outputs are combinational, so the bench drives them on a falling edge and compares them 1 ns later, before any rising edge. The mode status is due one rising edge after a configuration change and three rising edges after a pin change, provided the port is idle. The bench checks the old value after the first and second edges and the new value after the third. The discard flag is due one edge after the start strobe and clears one edge after the end strobe. Each of these registered results is sampled on the falling edge that follows the rising edge at which it is due.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  typedef enum logic {
    DPX_HALF = 1'b0,
    DPX_FULL = 1'b1
  } dpx_mode_e;

  // Half duplex needs both sources to agree: cfg bit low and pin high.
  function automatic dpx_mode_e dpx_resolve(input logic cfg_full, input logic pin_half);
    return (!cfg_full && pin_half) ? DPX_HALF : DPX_FULL;
  endfunction

endpackage

// File: rtl/dpx_sync.sv
module dpx_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = d_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];

  AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage_q[0] == $past(d_i)))
    else $error("first synchroniser stage missed input"); // R3

endmodule

// File: rtl/dpx_mode.sv
module dpx_mode
  import dpx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_half_s_i,
  input  logic cfg_full_i,
  input  logic tx_en_i,
  input  logic crs_i,
  output logic full_o
);

  dpx_mode_e mode_q;
  dpx_mode_e mode_d;
  dpx_mode_e mode_req;
  logic      port_idle;
  logic      mode_en;

  always_comb begin
    mode_req  = dpx_resolve(cfg_full_i, pin_half_s_i);
    port_idle = !tx_en_i && !crs_i;
    mode_en   = port_idle && (mode_req != mode_q);
    mode_d    = mode_en ? mode_req : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= DPX_HALF;
    else        mode_q <= mode_d;
  end

  assign full_o = (mode_q == DPX_FULL);

  AST_MODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_i || crs_i) |=> $stable(full_o))
    else $error("mode changed while port busy"); // R4

  AST_MODE_HALF_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (port_idle && cfg_full_i) |=> full_o)
    else $error("cfg full ignored while idle"); // R2

endmodule

// File: rtl/dpx_port_filter.sv
module dpx_port_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic full_i,
  input  logic own_drop_i,
  input  logic tx_en_i,
  input  logic crs_i,
  input  logic col_i,
  input  logic sof_i,
  input  logic eof_i,
  output logic crs_o,
  output logic col_o,
  output logic drop_o
);

  logic crs_q,  crs_d;
  logic loop_q, loop_d;
  logic drop_q, drop_d;
  logic crs_rise;
  logic loop_now;

  // next-state
  always_comb begin
    crs_rise = crs_i && !crs_q;
    loop_now = crs_rise ? tx_en_i : loop_q;
    crs_d    = crs_i;
    loop_d   = loop_now;
    if (sof_i)      drop_d = !full_i && own_drop_i && loop_now;
    else if (eof_i) drop_d = 1'b0;
    else            drop_d = drop_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q  <= 1'b0;
      loop_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      crs_q  <= crs_d;
      loop_q <= loop_d;
      drop_q <= drop_d;
    end
  end

  // gating toward the MAC
  always_comb begin
    col_o = full_i ? 1'b0 : col_i;
    crs_o = full_i ? (crs_i && !tx_en_i) : crs_i;
  end

  assign drop_o = drop_q;

  AST_DROP_ONLY_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop_o) |-> $past(!full_i && own_drop_i && sof_i))
    else $error("discard raised without half duplex start"); // R9

  AST_DROP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_o && !sof_i && !eof_i) |=> drop_o)
    else $error("discard dropped before frame end"); // R8

  AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_i && !sof_i) |=> !drop_o)
    else $error("discard survived frame end"); // R8

  AST_DROP_SOF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && eof_i && !full_i && own_drop_i && loop_q && !crs_rise) |=> drop_o)
    else $error("end strobe overrode start strobe"); // R11

endmodule

// File: rtl/eth_duplex_filter.sv
module eth_duplex_filter #(
  parameter int NPORT     = 4,
  parameter int PIN_SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] pin_half_i,
  input  logic [NPORT-1:0] cfg_full_i,
  input  logic [NPORT-1:0] own_drop_i,
  input  logic [NPORT-1:0] tx_en_i,
  input  logic [NPORT-1:0] crs_i,
  input  logic [NPORT-1:0] col_i,
  input  logic [NPORT-1:0] rx_sof_i,
  input  logic [NPORT-1:0] rx_eof_i,
  output logic [NPORT-1:0] crs_o,
  output logic [NPORT-1:0] col_o,
  output logic [NPORT-1:0] rx_drop_o,
  output logic [NPORT-1:0] full_o
);

  localparam logic [NPORT-1:0] PIN_RST = {NPORT{1'b1}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_core_n = rst_pipe_q[1];

  logic [NPORT-1:0] pin_half_s;

  dpx_sync #(
    .W       (NPORT),
    .STAGES  (PIN_SYNC),
    .RST_VAL (PIN_RST)
  ) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (pin_half_i),
    .q_o   (pin_half_s)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpx_mode u_mode (
      .clk          (clk),
      .rst_n        (rst_core_n),
      .pin_half_s_i (pin_half_s[p]),
      .cfg_full_i   (cfg_full_i[p]),
      .tx_en_i      (tx_en_i[p]),
      .crs_i        (crs_i[p]),
      .full_o       (full_o[p])
    );

    dpx_port_filter u_filter (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .full_i     (full_o[p]),
      .own_drop_i (own_drop_i[p]),
      .tx_en_i    (tx_en_i[p]),
      .crs_i      (crs_i[p]),
      .col_i      (col_i[p]),
      .sof_i      (rx_sof_i[p]),
      .eof_i      (rx_eof_i[p]),
      .crs_o      (crs_o[p]),
      .col_o      (col_o[p]),
      .drop_o     (rx_drop_o[p])
    );
  end

  AST_NO_COL_FULL: assert property (@(posedge clk) disable iff (!rst_core_n)
    (full_o & col_o) == '0)
    else $error("collision passed in full duplex"); // R5

  AST_RESET_HALF: assert property (@(posedge clk)
    !rst_core_n |-> (full_o == '0 && rx_drop_o == '0))
    else $error("reset state wrong"); // R1

endmodule

// File: tb/eth_duplex_filter_bench.sv
module eth_duplex_filter_bench;

  localparam int NP = 4;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] pin_half, cfg_full, own_drop, tx_en, crs, col, sof, eof;
  logic [NP-1:0] crs_g, col_g, drop, full;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  eth_duplex_filter #(.NPORT(NP)) u_eth_duplex_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_half_i (pin_half),
    .cfg_full_i (cfg_full),
    .own_drop_i (own_drop),
    .tx_en_i    (tx_en),
    .crs_i      (crs),
    .col_i      (col),
    .rx_sof_i   (sof),
    .rx_eof_i   (eof),
    .crs_o      (crs_g),
    .col_o      (col_g),
    .rx_drop_o  (drop),
    .full_o     (full)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 full_o in reset", full, 0);
    check("R1 rx_drop_o in reset", drop, 0);
    check("R1 col_o/crs_o in reset", {col_g, crs_g}, 0);
  endtask

  task automatic t_mode_table();
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic pv, cv;
        pv = c[1];
        cv = c[0];
        pin_half[p] = pv;
        cfg_full[p] = cv;
        repeat (4) tick();
        check($sformatf("R2 port %0d pin %0b cfg %0b", p, pv, cv),
              full[p], (!cv && pv) ? 0 : 1);
        check("R10 other ports stay half", full & ~(4'b1 << p), 0);
      end
      pin_half[p] = 1'b1;
      cfg_full[p] = 1'b0;
      repeat (4) tick();
    end
  endtask

  task automatic t_latency();
    pin_half[0] = 1'b0;
    repeat (4) tick();
    check("R3 pin full settled", full[0], 1);
    pin_half[0] = 1'b1;
    tick(); check("R3 pin edge1 unchanged", full[0], 1);
    tick(); check("R3 pin edge2 unchanged", full[0], 1);
    tick(); check("R3 pin edge3 applied", full[0], 0);
    cfg_full[0] = 1'b1;
    tick(); check("R3 cfg edge1 applied", full[0], 1);
    cfg_full[0] = 1'b0;
    tick(); check("R3 cfg edge1 back to half", full[0], 0);
  endtask

  task automatic t_busy();
    tx_en[1] = 1'b1;
    tick();
    cfg_full[1] = 1'b1;
    repeat (3) tick();
    check("R4 held while tx_en high", full[1], 0);
    tx_en[1] = 1'b0;
    crs[1]   = 1'b1;
    repeat (2) tick();
    check("R4 held while crs high", full[1], 0);
    crs[1] = 1'b0;
    tick();
    check("R4 applied at first idle edge", full[1], 1);
    cfg_full[1] = 1'b0;
    repeat (2) tick();
    check("R4 back to half", full[1], 0);
  endtask

  task automatic t_gating();
    cfg_full[2] = 1'b1;
    repeat (2) tick();
    col[2] = 1'b1; crs[2] = 1'b1; tx_en[2] = 1'b1;
    #1;
    check("R5 col masked in full", col_g[2], 0);
    check("R6 looped crs masked in full", crs_g[2], 0);
    check("R10 other ports untouched", {col_g[3], col_g[1:0], crs_g[3], crs_g[1:0]}, 0);
    tx_en[2] = 1'b0;
    #1;
    check("R6 crs passes in full without tx", crs_g[2], 1);
    col[2] = 1'b0; crs[2] = 1'b0;
    tick();
    cfg_full[2] = 1'b0;
    repeat (2) tick();
    check("R2 port 2 back to half", full[2], 0);
    col[2] = 1'b1; crs[2] = 1'b1; tx_en[2] = 1'b1;
    #1;
    check("R5 col passes in half", col_g[2], 1);
    check("R6 crs passes in half with tx", crs_g[2], 1);
    col[2] = 1'b0; crs[2] = 1'b0; tx_en[2] = 1'b0;
    repeat (2) tick();
  endtask

  task automatic t_frame(input int p, input bit half, input bit own,
                         input bit looped, input string req);
    logic exp;
    exp = half && own && looped;
    cfg_full[p] = !half;
    own_drop[p] = own;
    repeat (2) tick();
    if (looped) begin
      tx_en[p] = 1'b1; tick(); crs[p] = 1'b1; tick();
    end else begin
      crs[p] = 1'b1; tick(); tx_en[p] = 1'b1; tick();
    end
    sof[p] = 1'b1; tick(); sof[p] = 1'b0;
    check({req, " drop after sof"}, drop[p], exp);
    check("R10 no drop on other ports", drop & ~(4'b1 << p), 0);
    repeat (3) tick();
    check({req, " drop held"}, drop[p], exp);
    eof[p] = 1'b1; tick(); eof[p] = 1'b0;
    check("R8 drop clear after eof", drop[p], 0);
    tx_en[p] = 1'b0; crs[p] = 1'b0;
    repeat (2) tick();
    cfg_full[p] = 1'b0;
    own_drop[p] = 1'b0;
    repeat (2) tick();
  endtask

  task automatic t_sof_eof();
    own_drop[3] = 1'b1;
    tx_en[3] = 1'b1; tick(); crs[3] = 1'b1; tick();
    sof[3] = 1'b1; tick(); sof[3] = 1'b0;
    check("R7 looped frame flagged", drop[3], 1);
    sof[3] = 1'b1; eof[3] = 1'b1; tick(); sof[3] = 1'b0; eof[3] = 1'b0;
    check("R11 sof wins over eof", drop[3], 1);
    eof[3] = 1'b1; tick(); eof[3] = 1'b0;
    check("R8 cleared by lone eof", drop[3], 0);
    tx_en[3] = 1'b0; crs[3] = 1'b0; own_drop[3] = 1'b0;
    repeat (2) tick();
  endtask

  initial begin
    rst_n = 1'b0;
    pin_half = '1; cfg_full = '0; own_drop = '0;
    tx_en = '0; crs = '0; col = '0; sof = '0; eof = '0;
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    repeat (4) tick();
    t_mode_table();
    t_latency();
    t_busy();
    t_gating();
    t_frame(3, 1, 1, 1, "R8 half own looped");
    t_frame(3, 1, 1, 0, "R9 not looped");
    t_frame(1, 1, 0, 1, "R9 own_drop clear");
    t_frame(0, 0, 1, 1, "R9 full duplex");
    t_sof_eof();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule